// File: doc/BRIEF.md
# Cubic Spline Waveform Generator

This block produces one DAC sample on every clock. The sample follows a cubic polynomial in time, evaluated by a chain of four forward-difference accumulators. Software writes four coefficients into shadow registers through a word-wide write port. A one-cycle trigger then copies all four into the live accumulators on the same clock edge, and from then on the chain advances one step per clock.

The accumulator widths are mixed: 16, 32, 48 and 48 bits. The output stage is the 16-bit one. Wherever a wider stage feeds a narrower one, the narrower stage adds only the upper bits of the wider stage, so the bits that are discarded are the least significant ones. The output is a 16-bit two's-complement code spanning -10 V to +10 V minus one LSB, so one LSB is 20 V / 2^16. Host software scales the higher-order terms as follows:
- the slope term is scaled by 2^32 over the sample rate;
- the curvature term is scaled by 2 x 2^48 over the square of the sample rate;
- the cubic term is scaled by 6 x 2^48 over the cube of the sample rate.

A small controller sequences the chain. It has two states:
- ST_IDLE is entered on reset. In this state the accumulators hold their values.
- ST_RUN is the state in which the chain advances.

It has four transitions:
- T_START goes from ST_IDLE to ST_RUN on a trigger.
- T_WAIT stays in ST_IDLE when there is no trigger.
- T_RELOAD stays in ST_RUN on a trigger and reloads the accumulators.
- T_STEP stays in ST_RUN when there is no trigger and advances the chain.

Top module: `spline_gen`

## Requirements
- R1: A synchronous reset clears all four shadow registers and all four accumulators to zero, and puts the controller in ST_IDLE. The output reads 0 on the cycle after reset, and a trigger given after reset with no writes produces 0.
- R2: In ST_IDLE with no trigger, the output holds its value.
- R3: A write selects a coefficient with wr_addr[3:2] (0 = constant, 1 = slope, 2 = curvature, 3 = cubic) and a 16-bit word with wr_addr[1:0]. Word k holds bits 16k+15 down to 16k. The constant term has word 0 only, the slope term has words 0 and 1, and the other two terms have words 0 to 2. A write to a word beyond a coefficient's width changes nothing.
- R4: Writes to the shadow registers do not change the output, in either state, until a trigger.
- R5: A trigger copies all four shadow values into the accumulators on one edge. The output on the next cycle equals the loaded constant term, and the controller moves to ST_RUN.
- R6: In ST_RUN without a trigger, each clock updates the chain using the values from before that edge: a0 += a1[31:16], a1 += a2[47:16], a2 += a3. The cubic term a3 stays constant.
- R7: The low 16 bits of a1 never reach the output. For example, with a1 = 0x0000FFFF and a2 = a3 = 0, the output stays constant.
- R8: Every accumulator wraps modulo its own width, with no saturation. For example, 0x7FFF + 3 gives 0x8002.
- R9: A trigger in ST_RUN reloads all accumulators from the shadows. The reload overrides that cycle's step.
- R10: When a write and a trigger fall in the same cycle, the trigger loads the shadow contents from before that write. The written value takes effect only at the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Shadow word write strobe |
| wr_addr | input | 4 | Coefficient select [3:2], word select [1:0] |
| wr_data | input | 16 | Shadow word data |
| trig | input | 1 | One-cycle trigger: load shadows into accumulators |
| sample_out | output | 16 | Two's-complement output sample (a0) |

## Verification
The case hardest to reach from the ports is the interaction of the hidden higher-order accumulators. Their state shows up only through the upper bits that the chain passes down, so a broken slice or a wrong update order is visible only after many steps.

The bench uses two kinds of stimulus:
- Closed-form waveforms: a pure ramp that crosses the positive limit, and a pure quadratic that rises as n(n-1)/2. Their expected samples come from arithmetic in the bench.
- Generated coefficient sets that include the cubic term. These are run for hundreds of cycles and compared against a bench model of the recurrence.

A slope holding only low-order ones exposes any leak of the dropped bits. A write issued in the very cycle of a trigger shows which shadow contents were loaded.

// File: rtl/spline_pkg.sv
package spline_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    localparam int unsigned NUM_COEF   = 4;
    localparam int unsigned COEF_SEL_W = $clog2(NUM_COEF);
    localparam int unsigned WORD_SEL_W = 2;

    function automatic int unsigned words_for(input int unsigned width,
                                              input int unsigned word_w);
        return (width + word_w - 1) / word_w;
    endfunction

endpackage

// File: rtl/spline_ctrl.sv
module spline_ctrl
    import spline_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    output logic       load,
    output logic       advance,
    output gen_state_e state
);

    gen_state_e state_q;
    gen_state_e state_d;

    // Next-state decision: T_START, T_WAIT, T_RELOAD, T_STEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = trig ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output process
    always_comb begin
        load    = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: load = trig;
            ST_RUN: begin
                load    = trig;
                advance = !trig;
            end
            default: begin
                load    = 1'b0;
                advance = 1'b0;
            end
        endcase
    end

    assign state = state_q;

    // R5: any trigger leaves the controller running
    p_start_run_r5: assert property (@(posedge clk) disable iff (rst)
        trig |=> (state == ST_RUN));

    // R9: once running, only reset returns to idle
    p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> (state == ST_RUN));

    // R1: reset returns to idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));

endmodule

// File: rtl/coef_shadow.sv
module coef_shadow
    import spline_pkg::*;
#(
    parameter int unsigned COEF_W   = 32,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned COEF_IDX = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [COEF_SEL_W-1:0] wr_coef,
    input  logic [WORD_SEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0]     wr_data,
    output logic [COEF_W-1:0]     value
);

    localparam int unsigned NW = words_for(COEF_W, WORD_W);
    localparam logic [COEF_SEL_W-1:0] MY_SEL = COEF_SEL_W'(COEF_IDX);

    logic hit;
    assign hit = wr_en && (wr_coef == MY_SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (hit) begin
            for (int w = 0; w < NW; w++) begin
                if (wr_word == WORD_SEL_W'(w))
                    value[w*WORD_W +: WORD_W] <= wr_data;
            end
        end
    end

    // R3: a coefficient not addressed keeps its shadow
    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(value));

    // R1: reset clears the shadow
    p_shadow_clear_r1: assert property (@(posedge clk)
        rst |=> (value == '0));

endmodule

// File: rtl/spline_stage.sv
module spline_stage #(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             advance,
    input  logic [ACC_W-1:0] load_val,
    input  logic [ACC_W-1:0] feed,
    output logic [OUT_W-1:0] upper
);

    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst)          acc <= '0;
        else if (load)    acc <= load_val;
        else if (advance) acc <= acc + feed;
    end

    // Only the most significant bits leave the stage
    generate
        if (OUT_W == ACC_W) begin : g_full
            assign upper = acc;
        end else begin : g_top
            assign upper = acc[ACC_W-1 -: OUT_W];
        end
    endgenerate

    // R2: without load or step the accumulator holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(acc));

    // R5: a load takes the shadow value
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc == $past(load_val)));

endmodule

// File: rtl/spline_gen.sv
module spline_gen
    import spline_pkg::*;
#(
    parameter int unsigned W0     = 16,
    parameter int unsigned W1     = 32,
    parameter int unsigned W2     = 48,
    parameter int unsigned W3     = 48,
    parameter int unsigned WORD_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [COEF_SEL_W+WORD_SEL_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]                wr_data,
    input  logic                             trig,
    output logic [W0-1:0]                    sample_out
);

    localparam int unsigned ADDR_W = COEF_SEL_W + WORD_SEL_W;

    logic [COEF_SEL_W-1:0] sel_coef;
    logic [WORD_SEL_W-1:0] sel_word;
    assign sel_coef = wr_addr[ADDR_W-1 -: COEF_SEL_W];
    assign sel_word = wr_addr[WORD_SEL_W-1:0];

    logic [W0-1:0] sh0;
    logic [W1-1:0] sh1;
    logic [W2-1:0] sh2;
    logic [W3-1:0] sh3;

    logic [W0-1:0] up1;
    logic [W1-1:0] up2;
    logic [W2-1:0] up3;

    logic       load;
    logic       advance;
    gen_state_e state;

    spline_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .load    (load),
        .advance (advance),
        .state   (state)
    );

    coef_shadow #(.COEF_W(W0), .WORD_W(WORD_W), .COEF_IDX(0)) u_sh0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_coef(sel_coef),
        .wr_word(sel_word), .wr_data(wr_data), .value(sh0));
    coef_shadow #(.COEF_W(W1), .WORD_W(WORD_W), .COEF_IDX(1)) u_sh1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_coef(sel_coef),
        .wr_word(sel_word), .wr_data(wr_data), .value(sh1));
    coef_shadow #(.COEF_W(W2), .WORD_W(WORD_W), .COEF_IDX(2)) u_sh2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_coef(sel_coef),
        .wr_word(sel_word), .wr_data(wr_data), .value(sh2));
    coef_shadow #(.COEF_W(W3), .WORD_W(WORD_W), .COEF_IDX(3)) u_sh3 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_coef(sel_coef),
        .wr_word(sel_word), .wr_data(wr_data), .value(sh3));

    // Each stage adds the upper bits of the stage above it
    spline_stage #(.ACC_W(W0), .OUT_W(W0)) u_st0 (
        .clk(clk), .rst(rst), .load(load), .advance(advance),
        .load_val(sh0), .feed(up1), .upper(sample_out));
    spline_stage #(.ACC_W(W1), .OUT_W(W0)) u_st1 (
        .clk(clk), .rst(rst), .load(load), .advance(advance),
        .load_val(sh1), .feed(up2), .upper(up1));
    spline_stage #(.ACC_W(W2), .OUT_W(W1)) u_st2 (
        .clk(clk), .rst(rst), .load(load), .advance(advance),
        .load_val(sh2), .feed(up3), .upper(up2));
    spline_stage #(.ACC_W(W3), .OUT_W(W2)) u_st3 (
        .clk(clk), .rst(rst), .load(load), .advance(advance),
        .load_val(sh3), .feed('0), .upper(up3));

    // R1: output is zero after reset
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (sample_out == '0));

    // R2: idle without trigger keeps the output
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && !trig) |=> $stable(sample_out));

    // R5: the sample after a trigger is the shadow constant term
    p_trig_load_r5: assert property (@(posedge clk) disable iff (rst)
        trig |=> (sample_out == $past(sh0)));

    // R7: a step with zero upper slope bits leaves the output alone
    p_lsb_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (advance && (up1 == '0)) |=> $stable(sample_out));

endmodule

// File: tb/spline_gen_tb.sv
module spline_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trig = 1'b0;
    logic [15:0] sample_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m0 = '0;
    logic [31:0] m1 = '0;
    logic [47:0] m2 = '0, m3 = '0;
    logic [15:0] s0 = '0;
    logic [31:0] s1 = '0;
    logic [47:0] s2 = '0, s3 = '0;
    bit          mrun = 1'b0;
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

    always #5 clk = ~clk;

    spline_gen u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig(trig), .sample_out(sample_out));

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: inputs set at negedge, model updated at posedge
    task automatic cyc(input logic we, input logic [3:0] a,
                       input logic [15:0] d, input logic tg);
        logic [15:0] n0;
        logic [31:0] n1;
        logic [47:0] n2;
        int c, w;
        wr_en = we; wr_addr = a; wr_data = d; trig = tg;
        @(posedge clk);
        if (rst) begin
            m0 = '0; m1 = '0; m2 = '0; m3 = '0;
            s0 = '0; s1 = '0; s2 = '0; s3 = '0;
            mrun = 1'b0;
        end else begin
            n0 = m0 + m1[31:16];
            n1 = m1 + m2[47:16];
            n2 = m2 + m3;
            if (tg) begin
                m0 = s0; m1 = s1; m2 = s2; m3 = s3; mrun = 1'b1;
            end else if (mrun) begin
                m0 = n0; m1 = n1; m2 = n2;
            end
            if (we) begin
                c = int'(a[3:2]); w = int'(a[1:0]);
                if (c == 0 && w == 0) s0 = d;
                if (c == 1 && w < 2)  s1[w*16 +: 16] = d;
                if (c == 2 && w < 3)  s2[w*16 +: 16] = d;
                if (c == 3 && w < 3)  s3[w*16 +: 16] = d;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; trig = 1'b0;
    endtask

    task automatic wr(input int c, input int w, input logic [15:0] d);
        cyc(1'b1, {2'(c), 2'(w)}, d, 1'b0);
    endtask

    task automatic load_coef(input int c, input logic [47:0] v);
        int nw;
        nw = (c == 0) ? 1 : (c == 1) ? 2 : 3;
        for (int w = 0; w < nw; w++) wr(c, w, v[w*16 +: 16]);
    endtask

    task automatic clear_shadows();
        for (int c = 0; c < 4; c++) load_coef(c, 48'h0);
    endtask

    task automatic fire();
        cyc(1'b0, 4'h0, 16'h0, 1'b1);
    endtask

    task automatic idle();
        cyc(1'b0, 4'h0, 16'h0, 1'b0);
    endtask

    function automatic logic [47:0] rnd48();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed[63:16];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) idle();
        rst = 1'b0;
        check("R1 reset output", sample_out, 16'h0000);

        for (int i = 0; i < 5; i++) begin
            idle();
            check("R2 idle hold", sample_out, 16'h0000);
        end

        // R4: writes in idle do not reach the output
        wr(0, 0, 16'h1234);
        check("R4 write idle no effect", sample_out, 16'h0000);
        wr(0, 1, 16'hFFFF); // R3: word beyond a0 width ignored
        check("R4 ignored word no effect", sample_out, 16'h0000);
        fire();
        check("R5 trigger loads a0 (R3 word ignored)", sample_out, 16'h1234);
        for (int i = 0; i < 4; i++) begin
            idle();
            check("R6 constant waveform", sample_out, 16'h1234);
        end

        // R8 ramp across the positive limit, with writes during run (R4)
        clear_shadows();
        load_coef(0, 48'h7FF0);
        load_coef(1, 48'h0003_0000);
        fire();
        check("R5 ramp start", sample_out, 16'h7FF0);
        for (int n = 1; n <= 20; n++) begin
            if (n == 5) cyc(1'b1, 4'b0000, 16'h0000, 1'b0);
            else if (n == 9) cyc(1'b1, 4'b0101, 16'h00FF, 1'b0);
            else idle();
            check("R8 ramp wrap / R4 run write", sample_out,
                  16'h7FF0 + 16'(3 * n));
        end

        // R7: low slope bits never reach the output
        clear_shadows();
        load_coef(0, 48'h0005);
        load_coef(1, 48'h0000_FFFF);
        fire();
        for (int n = 0; n < 30; n++) begin
            check("R7 lsb dropped", sample_out, 16'h0005);
            idle();
        end

        // R6 quadratic: a0(n) = n(n-1)/2
        clear_shadows();
        load_coef(2, 48'h0001_0000_0000);
        fire();
        for (int n = 0; n <= 40; n++) begin
            check("R6 quadratic", sample_out, 16'((n * (n - 1)) / 2));
            idle();
        end

        // R6 cubic sweeps against the recurrence model
        for (int set = 0; set < 6; set++) begin
            load_coef(0, rnd48());
            load_coef(1, rnd48() >> 12);
            load_coef(2, rnd48() >> 8);
            load_coef(3, (set == 0) ? 48'h0 : (rnd48() >> 10));
            fire();
            for (int n = 0; n < 300; n++) begin
                check("R6 cubic sweep", sample_out, m0);
                idle();
            end
        end

        // R9 retrigger in run
        load_coef(0, 48'h4321);
        idle();
        fire();
        check("R9 retrigger reload", sample_out, 16'h4321);

        // R10 write and trigger in one cycle
        cyc(1'b1, 4'b0000, 16'h0BAD, 1'b1);
        check("R10 trigger uses pre-write shadow", sample_out, 16'h4321);
        fire();
        check("R10 written value at next trigger", sample_out, 16'h0BAD);

        // R1 reset mid-run clears shadows too
        rst = 1'b1;
        idle();
        rst = 1'b0;
        check("R1 reset mid-run", sample_out, 16'h0000);
        fire();
        check("R1 shadows cleared", sample_out, 16'h0000);
        for (int i = 0; i < 5; i++) begin
            idle();
            check("R1 zero after reset trigger", sample_out, 16'h0000);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule